// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A synthesizable single-port memory for a chip's internal bus. It captures an address on a clock edge, runs a four-beat burst from that address, writes any chosen set of 9-bit byte lanes, and returns registered read data one clock after each access. The word is 36 bits wide and made of four lanes, each carrying 8 data bits and 1 parity bit.

An access starts when either of two active-low address strobes is sampled low and both selects are active. One strobe serves a processor and one serves a controller. The two low address bits seed a 2-bit beat counter. A low advance input then steps the counter through a linear or an interleaved order, and it never carries into the upper address bits. A sleep input takes the core into power-down and back out, each with a two-clock latency. Strobes that arrive in the first two clocks after wake-up are ignored.

Top module: `burst_sram_core`

## Requirements
- R1: When either strobe (`strb_proc_n` or `strb_ctrl_n`) is low, `sel_lo_n` is low and `sel_hi` is high, the address is captured on that edge. Read data for it is on `rdata` with `rdata_en` high one clock later.
- R2: A strobe sampled low while `sel_lo_n` is high or `sel_hi` is low performs no access and ends any burst: nothing is written and `rdata_en` is low after that edge.
- R3: With `order_ilv` low, the beat address low bits are (seed + n) mod 4, where n counts the low `adv_n` edges since capture and no strobe is sampled on those edges.
- R4: With `order_ilv` high, the beat address low bits are seed XOR n.
- R5: After four advances the beat returns to the seed. Bits above bit 1 of the address never change during a burst.
- R6: A low `wr_all_n` on an access edge writes all four lanes from `wdata` to the current beat address.
- R7: With `wr_all_n` high and `wr_byte_n` low, only the lanes whose `lane_we_n` bit is low are written. Bit i of `lane_we_n` controls `wdata[9*i+8:9*i]`.
- R8: An access started by `strb_proc_n` is always a read: the write inputs are ignored on that edge.
- R9: `rdata_en` is high only while `oe_n` is low and the previous edge performed a read. A write edge leaves it low.
- R10: `sleep` sampled high enters power-down two edges later. In power-down `rdata_en` is low and strobes, advances and writes have no effect.
- R11: `sleep` sampled low leaves power-down two edges later. Strobes on the next two edges are ignored.
- R12: After reset `rdata_en` is low and the core is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address; bits [1:0] seed the beat counter |
| strb_proc_n | input | 1 | Processor address strobe, active low (read only) |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| order_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_en | output | 1 | Read bus drive enable (low means high-impedance) |

## Verification
A wrong beat counter or base register shows up on the very next `rdata` as a word from the wrong address. The sweep over every base, seed and order therefore catches it within one clock. A lane-write fault stays hidden until that word is read back, so every write is followed by a read of the same address. Faults in the sleep pipeline or the lockout change the edge on which `rdata_en` drops, or let a stray strobe store data. Each of these is visible within four clocks of the `sleep` change.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } beat_order_e;

    // Low address bits for beat number step within a four-beat burst
    function automatic logic [1:0] beat_lsb(input logic [1:0] seed,
                                            input logic [1:0] step,
                                            input beat_order_e ord);
        if (ord == ORD_INTERLEAVE) return seed ^ step;
        return seed + step;
    endfunction

endpackage

// File: rtl/bsr_sleep_ctl.sv
module bsr_sleep_ctl #(
    parameter int LOCK_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic pd,
    output logic lock_busy
);
    localparam int LCW = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic           sl1;
        logic           pd;
        logic [LCW-1:0] lock;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.sl1 = sleep;
        st_d.pd  = st_q.sl1;
        if (st_q.pd && !st_q.sl1)
            st_d.lock = LCW'(LOCK_CYC);
        else if (st_q.lock != '0)
            st_d.lock = st_q.lock - LCW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd        = st_q.pd;
    assign lock_busy = (st_q.lock != '0);
endmodule

// File: rtl/bsr_addr_seq.sv
module bsr_addr_seq
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              order_ilv,
    input  logic              pd,
    input  logic              lock_busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              op_valid,
    output logic              capture,
    output logic              proc_start
);
    localparam int BASE_W = ADDR_W - 2;

    typedef struct packed {
        logic              active;
        logic [BASE_W-1:0] base;
        logic [1:0]        seed;
        logic [1:0]        step;
    } st_t;

    st_t  st_q, st_d;
    logic strobe, go, selected;

    always_comb begin
        strobe   = !strb_proc_n || !strb_ctrl_n;
        selected = !sel_lo_n && sel_hi;
        go       = strobe && !pd && !lock_busy;
        capture  = go && selected;
        st_d     = st_q;
        if (pd) begin
            st_d.active = 1'b0;
        end else if (go) begin
            st_d.active = selected;
            if (selected) begin
                st_d.base = addr[ADDR_W-1:2];
                st_d.seed = addr[1:0];
                st_d.step = 2'd0;
            end
        end else if (st_q.active && !adv_n) begin
            st_d.step = st_q.step + 2'd1;
        end
        op_valid   = !pd && (capture || (!go && st_q.active));
        proc_start = capture && !strb_proc_n;
        cur_addr   = {st_d.base, beat_lsb(st_d.seed, st_d.step, beat_order_e'(order_ilv))};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bsr_lane_mem.sv
module bsr_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic                    rd_only,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t               st_q, st_d;
    logic [LANES-1:0]  lane_wr;
    logic [DATA_W-1:0] rword;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        assign lane_wr[i] = op_valid && !rd_only &&
                            (!wr_all_n || (!wr_byte_n && !lane_we_n[i]));
        assign rword[i*LANE_W +: LANE_W] = mem[addr];
        always_ff @(posedge clk) begin
            if (lane_wr[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.rd = op_valid && (lane_wr == '0);
        if (st_d.rd) st_d.data = rword;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.data;
    assign rd_q  = st_q.rd;
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strb_proc_n,
    input  logic                    strb_ctrl_n,
    input  logic                    adv_n,
    input  logic                    sel_lo_n,
    input  logic                    sel_hi,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    order_ilv,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);
    logic              pd, lock_busy, op_valid, capture, proc_start, rd_q;
    logic [ADDR_W-1:0] cur_addr;

    bsr_sleep_ctl #(.LOCK_CYC(2)) u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .pd(pd), .lock_busy(lock_busy)
    );

    bsr_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
        .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .order_ilv(order_ilv),
        .pd(pd), .lock_busy(lock_busy), .cur_addr(cur_addr),
        .op_valid(op_valid), .capture(capture), .proc_start(proc_start)
    );

    bsr_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .rd_only(proc_start),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
        .addr(cur_addr), .wdata(wdata), .rdata(rdata), .rd_q(rd_q)
    );

    assign rdata_en = rd_q && !oe_n && !pd;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic oe_n,
    input logic strb_proc_n,
    input logic strb_ctrl_n,
    input logic sel_lo_n,
    input logic sel_hi,
    input logic rdata_en,
    input logic pd,
    input logic lock_busy,
    input logic capture,
    input logic rd_q
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= 2'd0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    assert_oe_gates_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> !oe_n);

    assert_pd_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> !rdata_en);

    assert_sleep_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (pd == $past(sleep, 2)));

    assert_lockout_no_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy |-> !capture);

    assert_deselect_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_proc_n || !strb_ctrl_n) && !(!sel_lo_n && sel_hi)) |=> !rd_q);

    assert_proc_strobe_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !strb_proc_n) |=> rd_q);
endmodule

bind burst_sram_core bsr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .rdata_en(rdata_en),
    .pd(pd), .lock_busy(lock_busy), .capture(capture), .rd_q(rd_q)
);

// File: tb/burst_sram_core_bench.sv
`timescale 1ns/1ps
module burst_sram_core_bench;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
    logic        sel_lo_n = 1'b0, sel_hi = 1'b1;
    logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0]  lane_we_n = 4'hF;
    logic        oe_n = 1'b0, sleep = 1'b0, order_ilv = 1'b0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_en;

    logic [35:0] exp_mem [NW];
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_sram_core u_burst_sram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
        .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .sel_lo_n(sel_lo_n),
        .sel_hi(sel_hi), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep),
        .order_ilv(order_ilv), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_we_n = 4'hF;
        sel_lo_n = 1'b0; sel_hi = 1'b1;
    endtask

    function automatic logic [35:0] fill(input int a);
        return (36'(a) * 36'h0_0101_0107) ^ 36'hA_5A5A_5A5A;
    endfunction

    task automatic write_all(input int a, input logic [35:0] d);
        idle(); addr = AW'(a); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; wdata = d;
        tick();
        exp_mem[a] = d;
        check("R9 write edge leaves bus off", 36'(rdata_en), 36'd0);
        idle();
    endtask

    task automatic read_one(input string req, input int a, input bit use_proc);
        idle(); addr = AW'(a);
        if (use_proc) strb_proc_n = 1'b0; else strb_ctrl_n = 1'b0;
        tick();
        check(req, 36'(rdata_en), 36'd1);
        check(req, rdata, exp_mem[a]);
        idle();
    endtask

    initial begin
        repeat (3) tick();
        check("R12 reset bus off", 36'(rdata_en), 36'd0);
        rst_n = 1'b1;
        tick();
        check("R12 awake after reset", 36'(rdata_en), 36'd0);

        // R6: fill every word with a global write
        for (int a = 0; a < NW; a++) write_all(a, fill(a));
        read_one("R1 R6 single read", 9, 1'b0);

        // R1 R3 R4 R5: every base, seed and order, with wrap
        for (int g = 0; g < NW / 4; g++) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 2; o++) begin
                    idle(); order_ilv = o[0]; addr = AW'(g * 4 + s);
                    if (o == 0) strb_ctrl_n = 1'b0; else strb_proc_n = 1'b0;
                    tick();
                    check("R1 capture beat", rdata, exp_mem[g * 4 + s]);
                    check("R1 bus on", 36'(rdata_en), 36'd1);
                    idle(); adv_n = 1'b0;
                    for (int k = 1; k <= 4; k++) begin
                        int lo;
                        tick();
                        lo = (o == 1) ? (s ^ (k % 4)) : ((s + k) % 4);
                        if (o == 1) check("R4 interleaved beat R5", rdata, exp_mem[g * 4 + lo]);
                        else        check("R3 linear beat R5", rdata, exp_mem[g * 4 + lo]);
                    end
                    idle(); order_ilv = 1'b0;
                end
            end
        end

        // R7: every lane mask
        for (int m = 0; m < 16; m++) begin
            logic [35:0] d;
            d = fill(m + 100);
            idle(); addr = AW'(21); strb_ctrl_n = 1'b0; wr_byte_n = 1'b0;
            lane_we_n = ~m[3:0]; wdata = d;
            tick();
            for (int i = 0; i < 4; i++)
                if (m[i]) exp_mem[21][i*9 +: 9] = d[i*9 +: 9];
            read_one("R7 lane write mask", 21, 1'b1);
        end

        // R6 over R7: global write wins over lane mask
        idle(); addr = AW'(22); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; wr_byte_n = 1'b0;
        lane_we_n = 4'hE; wdata = 36'h1_2345_6789;
        tick();
        exp_mem[22] = 36'h1_2345_6789;
        read_one("R6 all lanes despite mask", 22, 1'b0);

        // R8: processor strobe ignores write inputs
        idle(); addr = AW'(30); strb_proc_n = 1'b0; wr_all_n = 1'b0; wdata = 36'hF_FFFF_0000;
        tick();
        check("R8 proc strobe reads", rdata, exp_mem[30]);
        check("R8 proc strobe bus on", 36'(rdata_en), 36'd1);
        read_one("R8 word unchanged", 30, 1'b0);

        // R2: deselected strobes
        idle(); addr = AW'(31); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; sel_hi = 1'b0;
        wdata = 36'h0_0000_0BAD;
        tick();
        check("R2 deselect bus off", 36'(rdata_en), 36'd0);
        idle(); addr = AW'(31); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; sel_lo_n = 1'b1;
        tick();
        check("R2 deselect bus off", 36'(rdata_en), 36'd0);
        idle(); tick();
        check("R2 burst ended", 36'(rdata_en), 36'd0);
        read_one("R2 no write when deselected", 31, 1'b1);

        // R9: output enable high hides a read
        idle(); addr = AW'(12); strb_ctrl_n = 1'b0; oe_n = 1'b1;
        tick();
        check("R9 oe high bus off", 36'(rdata_en), 36'd0);
        oe_n = 1'b0; #1;
        check("R9 oe low bus on", 36'(rdata_en), 36'd1);
        idle();

        // R10 R11: sleep entry, power-down, wake, lockout
        read_one("R10 setup", 40, 1'b0);
        sleep = 1'b1;
        tick();
        check("R10 one edge after sleep still on", 36'(rdata_en), 36'd1);
        tick();
        check("R10 two edges after sleep off", 36'(rdata_en), 36'd0);
        idle(); addr = AW'(41); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
        tick();
        check("R10 strobe in power-down", 36'(rdata_en), 36'd0);
        idle(); tick();
        sleep = 1'b0;
        tick();
        check("R11 one edge after wake still down", 36'(rdata_en), 36'd0);
        tick();
        idle(); addr = AW'(41); strb_ctrl_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h0_0BAD_F00D;
        tick();
        check("R11 lockout edge 1 ignored", 36'(rdata_en), 36'd0);
        idle(); addr = AW'(41); strb_proc_n = 1'b0;
        tick();
        check("R11 lockout edge 2 ignored", 36'(rdata_en), 36'd0);
        read_one("R11 strobe accepted after lockout R10", 41, 1'b1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule